// File: doc/BRIEF.md
# Blinking Tile Character Display Generator

This block turns character-cell timing from a CRT-controller-style raster counter into a stream of 6-bit pen indices, one pixel per clock. For every cell it receives a single strobe carrying the cell's memory address, the scanline inside the character row, the screen column and row, and the current cursor column. It then reads a 16-bit cell word as two bytes from video RAM, looks up three bitplanes of glyph data in a character ROM divided into three equal planes, and shifts eight pixels out.

The cell word holds a 10-bit glyph number, a 3-bit colour group and a blink flag. When a cell has the blink flag set and the blink phase is off, the glyph is replaced by glyph 0. The phase is not timed inside the block. It is captured once per frame: on the strobe for scanline 0 at memory address 0, the phase turns on if the cursor column is 0 and off otherwise. Cells are 8 pixels wide and 10 scanlines tall. Only the 74 by 24 cell area is drawn. Everything else in the 88 by 27 raster comes out as pen 0.

Top module: `tile_pix_gen`

## Requirements
- R1: After reset, pix_vld_o is low and pen_o is 0.
- R2: One clock after a strobe, vram_lo_addr_o equals 2 × ma_i and vram_hi_addr_o equals 2 × ma_i + 1. The cell word is vram_lo_i in bits 7:0 and vram_hi_i in bits 15:8.
- R3: Two clocks after a strobe, plane p of rom_addr_o (bits 16p+15:16p) equals p × 16384 + glyph × 16 + scanline. The glyph is word bits 9:0. Word bits 11:10 have no effect on the glyph.
- R4: The pen equals word bits 14:12 in pen bits 5:3, plane 2 in bit 2, plane 1 in bit 1 and plane 0 in bit 0. Pixels come out from ROM byte bit 7 down to bit 0.
- R5: The first pixel of a cell appears 4 clocks after its strobe. pix_vld_o is high for exactly 8 consecutive clocks.
- R6: A cell with word bit 15 set is drawn as glyph 0 while the blink phase is off. Its colour group is kept. While the phase is on, the cell is drawn with its own glyph.
- R7: The blink phase is off after reset. It changes only on a strobe with ra_i = 0 and ma_i = 0, where it becomes (cursor_col_i == 0). That same cell already uses the new phase.
- R8: A cell with col_i ≥ 74 or row_i ≥ 24 produces pen 0 on all 8 pixels, while pix_vld_o still runs.
- R9: Strobes spaced exactly 8 clocks apart produce an unbroken pixel stream with no gap and no overlap.
- R10: Whenever pix_vld_o is low, pen_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_stb_i | input | 1 | Start of a character cell |
| ma_i | input | 16 | Cell memory address |
| ra_i | input | 4 | Scanline within the character row (0 to 9) |
| col_i | input | 7 | Cell column in the raster |
| row_i | input | 5 | Character row in the raster |
| cursor_col_i | input | 7 | Current cursor column |
| vram_lo_addr_o | output | 17 | Video RAM address of the cell word low byte |
| vram_hi_addr_o | output | 17 | Video RAM address of the cell word high byte |
| vram_lo_i | input | 8 | Low byte, one clock after its address |
| vram_hi_i | input | 8 | High byte, one clock after its address |
| rom_addr_o | output | 48 | Three 16-bit character ROM addresses, plane 0 in the low bits |
| rom_data_i | input | 24 | Three ROM bytes, one clock after their addresses, plane 0 in the low bits |
| pix_vld_o | output | 1 | Pixel valid |
| pen_o | output | 6 | Pen index |

## Verification
The bench targets these corner cases:

- **Blink phase.** It sets a cell's blink flag with the phase off and then on. A design that ignored the phase, or cleared the colour along with the glyph, would draw the wrong pens. It also strobes memory address 0 at a non-zero scanline, and scanline 0 at a non-zero address, with the cursor at column 0. A design that decoded the latch condition loosely would turn blinking cells on there. The cell that latches the phase is checked with its own blink flag set, which exposes a phase applied one cell late.
- **Hidden area.** Cells at column 74 and at row 24 must come out blank, while cells at column 73 and row 23 must not. An off-by-one visibility compare fails on one side or the other.
- **Glyph bits 11:10.** Cells carry these bits set, so a design that widened the glyph field would read ROM at the wrong address.
- **Back-to-back strobes.** Strobes 8 clocks apart catch a shifter that drops or repeats a pixel at the cell boundary.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int unsigned CELL_W_D     = 8;
  localparam int unsigned CELL_H_D     = 10;
  localparam int unsigned PLANES_D     = 3;
  localparam int unsigned GLYPH_BITS_D = 10;
  localparam int unsigned STRIDE_D     = 16;
  localparam int unsigned VIS_COLS_D   = 74;
  localparam int unsigned VIS_ROWS_D   = 24;
  localparam int unsigned TOT_COLS_D   = 88;
  localparam int unsigned TOT_ROWS_D   = 27;

  localparam int unsigned COLOR_LSB = 12;
  localparam int unsigned COLOR_W   = 3;
  localparam int unsigned BLINK_BIT = 15;
endpackage

// File: rtl/tpg_cell_fetch.sv
module tpg_cell_fetch #(
  parameter int unsigned MA_W     = 16,
  parameter int unsigned RA_W     = 4,
  parameter int unsigned COL_W    = 7,
  parameter int unsigned ROW_W    = 5,
  parameter int unsigned VIS_COLS = 74,
  parameter int unsigned VIS_ROWS = 24,
  localparam int unsigned VA_W    = MA_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cell_stb_i,
  input  logic [MA_W-1:0]  ma_i,
  input  logic [RA_W-1:0]  ra_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] cursor_col_i,
  output logic [VA_W-1:0]  vram_lo_addr_o,
  output logic [VA_W-1:0]  vram_hi_addr_o,
  output logic             s1_vld_o,
  output logic [RA_W-1:0]  s1_ra_o,
  output logic             s1_vis_o,
  output logic             blink_o
);
  logic vis_d, frame_top;

  assign vis_d     = (32'(col_i) < VIS_COLS) && (32'(row_i) < VIS_ROWS);
  assign frame_top = cell_stb_i && (ra_i == '0) && (ma_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_o       <= 1'b0;
      s1_ra_o        <= '0;
      s1_vis_o       <= 1'b0;
      vram_lo_addr_o <= '0;
      vram_hi_addr_o <= '0;
    end else begin
      s1_vld_o <= cell_stb_i;
      if (cell_stb_i) begin
        s1_ra_o        <= ra_i;
        s1_vis_o       <= vis_d;
        vram_lo_addr_o <= {ma_i, 1'b0};
        vram_hi_addr_o <= {ma_i, 1'b1};
      end
    end
  end

  // phase sampled once per frame from cursor position
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        blink_o <= 1'b0;
    else if (frame_top) blink_o <= (cursor_col_i == '0);
  end
endmodule

// File: rtl/tpg_glyph_addr.sv
module tpg_glyph_addr
  import tpg_pkg::*;
#(
  parameter int unsigned RA_W       = 4,
  parameter int unsigned PLANES     = 3,
  parameter int unsigned GLYPH_BITS = 10,
  parameter int unsigned STRIDE     = 16,
  localparam int unsigned PLANE_BYTES = (1 << GLYPH_BITS) * STRIDE,
  localparam int unsigned ROM_AW      = $clog2(PLANES * PLANE_BYTES)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     s1_vld_i,
  input  logic [RA_W-1:0]          s1_ra_i,
  input  logic                     s1_vis_i,
  input  logic                     blink_i,
  input  logic [7:0]               vram_lo_i,
  input  logic [7:0]               vram_hi_i,
  output logic [PLANES*ROM_AW-1:0] rom_addr_o,
  output logic                     s3_vld_o,
  output logic                     s3_vis_o,
  output logic [COLOR_W-1:0]       s3_color_o
);
  logic                  s2_vld, s2_vis;
  logic [RA_W-1:0]       s2_ra;
  logic [15:0]           word;
  logic [GLYPH_BITS-1:0] glyph;
  logic                  unused_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld <= 1'b0;
      s2_vis <= 1'b0;
      s2_ra  <= '0;
    end else begin
      s2_vld <= s1_vld_i;
      s2_vis <= s1_vis_i;
      s2_ra  <= s1_ra_i;
    end
  end

  assign word        = {vram_hi_i, vram_lo_i};
  assign glyph       = (word[BLINK_BIT] && !blink_i) ? '0 : word[GLYPH_BITS-1:0];
  assign unused_bits = ^word[COLOR_LSB-1:GLYPH_BITS];

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    assign rom_addr_o[p*ROM_AW +: ROM_AW] = ROM_AW'(p * PLANE_BYTES)
                                          + ROM_AW'(32'(glyph) * STRIDE)
                                          + ROM_AW'(s2_ra);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s3_vld_o   <= 1'b0;
      s3_vis_o   <= 1'b0;
      s3_color_o <= '0;
    end else begin
      s3_vld_o   <= s2_vld;
      s3_vis_o   <= s2_vis;
      s3_color_o <= word[COLOR_LSB +: COLOR_W];
    end
  end
endmodule

// File: rtl/tpg_pixel_shift.sv
module tpg_pixel_shift
  import tpg_pkg::*;
#(
  parameter int unsigned PLANES = 3,
  parameter int unsigned CELL_W = 8,
  localparam int unsigned CNT_W = $clog2(CELL_W + 1),
  localparam int unsigned PEN_W = COLOR_W + PLANES
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic                     vis_i,
  input  logic [COLOR_W-1:0]       color_i,
  input  logic [PLANES*CELL_W-1:0] rom_data_i,
  output logic                     pix_vld_o,
  output logic [PEN_W-1:0]         pen_o
);
  logic [PLANES-1:0][CELL_W-1:0] sh_q;
  logic [PLANES-1:0]             pix_bits;
  logic [CNT_W-1:0]              cnt_q;
  logic [COLOR_W-1:0]            color_q;
  logic                          vis_q;

  for (genvar p = 0; p < PLANES; p++) begin : g_sh
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            sh_q[p] <= '0;
      else if (load_i)        sh_q[p] <= rom_data_i[p*CELL_W +: CELL_W];
      else if (cnt_q != '0)   sh_q[p] <= {sh_q[p][CELL_W-2:0], 1'b0};
    end
    assign pix_bits[p] = sh_q[p][CELL_W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      color_q <= '0;
      vis_q   <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= CNT_W'(CELL_W);
      color_q <= color_i;
      vis_q   <= vis_i;
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign pix_vld_o = (cnt_q != '0);
  assign pen_o     = (pix_vld_o && vis_q) ? {color_q, pix_bits} : '0;
endmodule

// File: rtl/tile_pix_gen.sv
module tile_pix_gen
  import tpg_pkg::*;
#(
  parameter int unsigned MA_W       = 16,
  parameter int unsigned CELL_W     = CELL_W_D,
  parameter int unsigned CELL_H     = CELL_H_D,
  parameter int unsigned PLANES     = PLANES_D,
  parameter int unsigned GLYPH_BITS = GLYPH_BITS_D,
  parameter int unsigned STRIDE     = STRIDE_D,
  parameter int unsigned VIS_COLS   = VIS_COLS_D,
  parameter int unsigned VIS_ROWS   = VIS_ROWS_D,
  parameter int unsigned TOT_COLS   = TOT_COLS_D,
  parameter int unsigned TOT_ROWS   = TOT_ROWS_D,
  localparam int unsigned RA_W   = $clog2(CELL_H),
  localparam int unsigned COL_W  = $clog2(TOT_COLS),
  localparam int unsigned ROW_W  = $clog2(TOT_ROWS),
  localparam int unsigned VA_W   = MA_W + 1,
  localparam int unsigned ROM_AW = $clog2(PLANES * (1 << GLYPH_BITS) * STRIDE),
  localparam int unsigned PEN_W  = COLOR_W + PLANES
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cell_stb_i,
  input  logic [MA_W-1:0]          ma_i,
  input  logic [RA_W-1:0]          ra_i,
  input  logic [COL_W-1:0]         col_i,
  input  logic [ROW_W-1:0]         row_i,
  input  logic [COL_W-1:0]         cursor_col_i,
  output logic [VA_W-1:0]          vram_lo_addr_o,
  output logic [VA_W-1:0]          vram_hi_addr_o,
  input  logic [7:0]               vram_lo_i,
  input  logic [7:0]               vram_hi_i,
  output logic [PLANES*ROM_AW-1:0] rom_addr_o,
  input  logic [PLANES*CELL_W-1:0] rom_data_i,
  output logic                     pix_vld_o,
  output logic [PEN_W-1:0]         pen_o
);
  logic               s1_vld, s1_vis, blink_q;
  logic [RA_W-1:0]    s1_ra;
  logic               s3_vld, s3_vis;
  logic [COLOR_W-1:0] s3_color;

  tpg_cell_fetch #(
    .MA_W(MA_W), .RA_W(RA_W), .COL_W(COL_W), .ROW_W(ROW_W),
    .VIS_COLS(VIS_COLS), .VIS_ROWS(VIS_ROWS)
  ) u_fetch (
    .clk_i, .rst_ni, .cell_stb_i, .ma_i, .ra_i, .col_i, .row_i, .cursor_col_i,
    .vram_lo_addr_o, .vram_hi_addr_o,
    .s1_vld_o(s1_vld), .s1_ra_o(s1_ra), .s1_vis_o(s1_vis), .blink_o(blink_q)
  );

  tpg_glyph_addr #(
    .RA_W(RA_W), .PLANES(PLANES), .GLYPH_BITS(GLYPH_BITS), .STRIDE(STRIDE)
  ) u_glyph (
    .clk_i, .rst_ni,
    .s1_vld_i(s1_vld), .s1_ra_i(s1_ra), .s1_vis_i(s1_vis), .blink_i(blink_q),
    .vram_lo_i, .vram_hi_i, .rom_addr_o,
    .s3_vld_o(s3_vld), .s3_vis_o(s3_vis), .s3_color_o(s3_color)
  );

  tpg_pixel_shift #(.PLANES(PLANES), .CELL_W(CELL_W)) u_shift (
    .clk_i, .rst_ni, .load_i(s3_vld), .vis_i(s3_vis), .color_i(s3_color),
    .rom_data_i, .pix_vld_o, .pen_o
  );
endmodule

// File: rtl/tile_pix_gen_chk.sv
module tile_pix_gen_chk #(
  parameter int unsigned MA_W  = 16,
  parameter int unsigned RA_W  = 4,
  parameter int unsigned COL_W = 7,
  parameter int unsigned PEN_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cell_stb_i,
  input logic [MA_W-1:0]  ma_i,
  input logic [RA_W-1:0]  ra_i,
  input logic [COL_W-1:0] cursor_col_i,
  input logic             blink_q,
  input logic [MA_W:0]    vram_lo_addr_o,
  input logic [MA_W:0]    vram_hi_addr_o,
  input logic             pix_vld_o,
  input logic [PEN_W-1:0] pen_o
);
  p_idle_pen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_vld_o |-> (pen_o == '0));

  p_vram_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_stb_i |=> (vram_lo_addr_o == {$past(ma_i), 1'b0})
                && (vram_hi_addr_o == vram_lo_addr_o + 1'b1));

  p_first_pixel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_stb_i |-> ##4 pix_vld_o);

  p_blink_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cell_stb_i && ra_i == '0 && ma_i == '0) |=> $stable(blink_q));

  p_blink_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_stb_i && ra_i == '0 && ma_i == '0) |=> (blink_q == ($past(cursor_col_i) == '0)));
endmodule

bind tile_pix_gen tile_pix_gen_chk #(
  .MA_W(MA_W), .RA_W(RA_W), .COL_W(COL_W), .PEN_W(PEN_W)
) u_chk (
  .clk_i, .rst_ni, .cell_stb_i, .ma_i, .ra_i, .cursor_col_i, .blink_q,
  .vram_lo_addr_o, .vram_hi_addr_o, .pix_vld_o, .pen_o
);

// File: tb/tile_pix_gen_tb_top.sv
module tile_pix_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stb = 1'b0;
  logic [15:0] ma = '0;
  logic [3:0]  ra = '0;
  logic [6:0]  col = '0;
  logic [4:0]  row = '0;
  logic [6:0]  cur = 7'd5;
  logic [16:0] va_lo, va_hi;
  logic [7:0]  vd_lo, vd_hi;
  logic [47:0] rom_addr;
  logic [23:0] rom_data;
  logic        pix_vld;
  logic [5:0]  pen;

  logic [7:0] bmem [256];
  int n_chk = 0, n_fail = 0;
  bit blink_m = 1'b0;

  always #10 clk = ~clk;

  tile_pix_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cell_stb_i(stb), .ma_i(ma), .ra_i(ra),
    .col_i(col), .row_i(row), .cursor_col_i(cur),
    .vram_lo_addr_o(va_lo), .vram_hi_addr_o(va_hi), .vram_lo_i(vd_lo), .vram_hi_i(vd_hi),
    .rom_addr_o(rom_addr), .rom_data_i(rom_data), .pix_vld_o(pix_vld), .pen_o(pen)
  );

  function automatic logic [7:0] rom_fn(int a);
    return 8'(a * 37 + (a >> 5) * 11 + (a >> 11) * 91) ^ 8'h5a;
  endfunction

  always_ff @(posedge clk) begin
    vd_lo <= bmem[va_lo[7:0]];
    vd_hi <= bmem[va_hi[7:0]];
    for (int p = 0; p < 3; p++) rom_data[p*8 +: 8] <= rom_fn(int'(rom_addr[p*16 +: 16]));
  end

  function automatic int glyph_of(logic [15:0] w, bit bl);
    return (w[15] && !bl) ? 0 : int'(w[9:0]);
  endfunction

  function automatic logic [5:0] exp_pen(logic [15:0] w, int r, bit vis, bit bl, int k);
    logic [2:0] b;
    int g = glyph_of(w, bl);
    for (int p = 0; p < 3; p++) b[p] = rom_fn(p * 16384 + g * 16 + r)[7-k];
    return vis ? {w[14:12], b} : 6'd0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // writes memory, updates blink model, drives strobe; returns on the next negedge
  task automatic drive_cell(int m, int r, int c, int rw, int cu, logic [15:0] w,
                            output bit bl, output bit vis);
    bmem[(2*m) & 255]   = w[7:0];
    bmem[(2*m+1) & 255] = w[15:8];
    if (r == 0 && m == 0) blink_m = (cu == 0);
    bl  = blink_m;
    vis = (c < 74) && (rw < 24);
    ma = 16'(m); ra = 4'(r); col = 7'(c); row = 5'(rw); cur = 7'(cu);
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic run_cell(int m, int r, int c, int rw, int cu, logic [15:0] w, string req);
    bit bl, vis;
    int g;
    drive_cell(m, r, c, rw, cu, w, bl, vis);
    chk(va_lo == 17'(2*m) && va_hi == 17'(2*m+1), "R2", int'(va_lo), 2*m);
    @(negedge clk);
    g = glyph_of(w, bl);
    for (int p = 0; p < 3; p++)
      chk(int'(rom_addr[p*16 +: 16]) == p*16384 + g*16 + r, "R3", int'(rom_addr[p*16 +: 16]),
          p*16384 + g*16 + r);
    @(negedge clk);
    chk(!pix_vld, "R5", int'(pix_vld), 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(pix_vld, "R5", int'(pix_vld), 1);
      chk(pen == exp_pen(w, r, vis, bl, k), req, int'(pen), int'(exp_pen(w, r, vis, bl, k)));
    end
    @(negedge clk);
    chk(!pix_vld && pen == 0, "R5 R10", int'(pen), 0);
  endtask

  task automatic t_reset;
    chk(!pix_vld, "R1", int'(pix_vld), 0);
    chk(pen == 0, "R1", int'(pen), 0);
  endtask

  task automatic t_plain;
    run_cell(5, 3, 10, 2, 5, 16'h2123, "R4");
    run_cell(9, 9, 0, 0, 5, 16'h7301, "R4");
    run_cell(12, 0, 73, 23, 5, 16'h53ff, "R4 R8");
  endtask

  task automatic t_ignored_bits;
    run_cell(7, 6, 4, 4, 5, 16'h1eab, "R3");
  endtask

  task automatic t_blink;
    run_cell(20, 2, 1, 1, 3, 16'hb0c5, "R6");      // phase off -> glyph 0, colour 3
    run_cell(0, 4, 1, 1, 0, 16'h9055, "R7");       // ma 0 but scanline 4: no latch
    run_cell(3, 0, 1, 1, 0, 16'h9077, "R7");       // scanline 0 but ma 3: no latch
    run_cell(0, 0, 0, 0, 0, 16'hc1a2, "R7 R6");    // latch on, same cell shows glyph
    run_cell(21, 5, 2, 2, 9, 16'ha0c5, "R6");      // still on
    run_cell(0, 0, 0, 0, 7, 16'hc1a2, "R7 R6");    // latch off
  endtask

  task automatic t_hidden;
    run_cell(30, 1, 74, 0, 5, 16'h7155, "R8");
    run_cell(31, 1, 0, 24, 5, 16'h7155, "R8");
    run_cell(32, 8, 87, 26, 5, 16'h43c3, "R8");
  endtask

  task automatic t_stream;
    logic [15:0] ws [3] = '{16'h1111, 16'h62f0, 16'h3099};
    bit bls [3];
    bit viss [3];
    fork
      begin
        for (int i = 0; i < 3; i++) begin
          drive_cell(40 + i, 2 + i, 5 + i, 3, 5, ws[i], bls[i], viss[i]);
          repeat (7) @(negedge clk);
        end
      end
      begin
        repeat (4) @(negedge clk);
        for (int i = 0; i < 24; i++) begin
          int c = i / 8;
          chk(pix_vld, "R9", int'(pix_vld), 1);
          chk(pen == exp_pen(ws[c], 2 + c, viss[c], bls[c], i % 8), "R9", int'(pen),
              int'(exp_pen(ws[c], 2 + c, viss[c], bls[c], i % 8)));
          @(negedge clk);
        end
        chk(!pix_vld, "R9", int'(pix_vld), 0);
      end
    join
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_plain();
    t_ignored_bits();
    t_blink();
    t_hidden();
    t_stream();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule